// File: doc/BRIEF.md
# Interrupt and Bus-Request Arbiter

This block sits beside the sequencer of a small 8-bit processor core. At each boundary strobe from the core it decides whether execution goes on, whether the external bus is handed to another master, or whether an interrupt is serviced. Bus requests come first. Non-maskable interrupts come next, and maskable interrupts come last. A bus request is looked at on every machine-cycle boundary. Interrupts are looked at only on instruction boundaries.

The block also holds four pieces of state:
- the interrupt-enable flag;
- a falling-edge latch for the non-maskable input, so that a short pulse is kept until it is serviced;
- the halted status;
- a qualifier on the reset pin. Reset takes effect only after the pin has been low for a minimum number of clocks.

While reset is in effect, a clear strobe tells the core to zero its program counter, its I and R registers, and to select interrupt mode 0. When an interrupt is taken, the block sends the core a one-cycle service request together with the restart address.

Top module: `irq_bus_arbiter`

## Requirements
- R1: When several events are eligible at the same boundary, only the highest one acts. The order is: bus request (`busreq_n` low with `mcyc_end`), then a pending NMI, then an enabled INT. A bus grant blocks interrupt service for as long as it lasts.
- R2: The bus is granted on the clock edge where `busreq_n` is low and `mcyc_end` is high, whatever the state of `instr_end`. While `mcyc_end` is low, a bus request has no effect. The grant ends on the first edge where `busreq_n` is high.
- R3: While the bus is granted, `busack_n` is 0 and `bus_float` is 1. At all other times, `busack_n` is 1 and `bus_float` is 0.
- R4: A 1-to-0 transition of `nmi_n` sets an NMI pending latch. The latch stays set across any number of cycles until the NMI is serviced. The enable flag does not affect it. Holding `nmi_n` low does not set it again.
- R5: A pending NMI is serviced at the first `instr_end` without a bus grant. Service means `svc_req` is 1, `svc_nmi` is 1 and `svc_addr` is 16'h0066. Service clears the latch.
- R6: INT is serviced only on an `instr_end` edge where `int_n` is low, the enable flag is set and no NMI is pending. Service means `svc_req` is 1, `svc_nmi` is 0 and `svc_addr` is INT_ADDR (default 16'h0038).
- R7: `ie_set` sets the enable flag and `ie_clr` clears it; `ie_clr` wins if both are high. Taking any interrupt clears the flag, and this wins over `ie_set`. The flag is visible on `iff_q`.
- R8: Reset acts only after `rst_pin_n` has been sampled low on RST_MIN consecutive edges (default 3). From then on `rst_clr` is 1 until the pin returns high. A shorter low pulse changes nothing.
- R9: While reset is in effect, the following are cleared: the enable flag, the NMI latch, the bus grant, the halted status and the service outputs.
- R10: `halt_req` drives `halt_n` to 0 from the next edge. `halt_n` stays 0 through boundaries with no eligible interrupt and through a bus grant. It returns to 1 on the edge that services an NMI or an enabled INT.
- R11: `svc_req` is registered on the deciding `instr_end` edge. It lasts one cycle unless the next edge services again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Raw reset pin, active low, qualified by width |
| busreq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge sensitive |
| int_n | input | 1 | Maskable interrupt, active-low level |
| mcyc_end | input | 1 | Core strobe: machine-cycle boundary |
| instr_end | input | 1 | Core strobe: instruction boundary |
| ie_set | input | 1 | Set interrupt-enable flag |
| ie_clr | input | 1 | Clear interrupt-enable flag |
| halt_req | input | 1 | Core executed a halt instruction |
| busack_n | output | 1 | Bus granted, active low |
| bus_float | output | 1 | Float address, data and strobe drivers |
| svc_req | output | 1 | Interrupt service request pulse |
| svc_nmi | output | 1 | Service is for NMI (1) or INT (0) |
| svc_addr | output | ADDR_W | Restart address for the service |
| halt_n | output | 1 | Halted status, active low |
| iff_q | output | 1 | Interrupt-enable flag |
| rst_clr | output | 1 | Clear PC, I, R and set interrupt mode 0 |

## Verification
The main function is the priority decision. It is driven from a table that combines the enable flag, a pending NMI, an active INT and a bus request at one boundary that is both a machine-cycle and an instruction boundary. The table shows which single winner comes out of each combination, and that a cleared flag masks INT but not NMI. Directed sequences then separate the other behaviours:
- machine-cycle boundaries from instruction boundaries, by requesting the bus mid-instruction;
- edge detection from level detection, with a one-cycle NMI pulse and with NMI held low;
- a short reset pulse from a qualified one;
- halt wake-ups from events that must leave the core halted.

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter #(
  parameter int              ADDR_W   = 16,
  parameter int              RST_MIN  = 3,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 16'h0066,
  parameter logic [ADDR_W-1:0] INT_ADDR = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              busreq_n,
  input  logic              nmi_n,
  input  logic              int_n,
  input  logic              mcyc_end,
  input  logic              instr_end,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              halt_req,
  output logic              busack_n,
  output logic              bus_float,
  output logic              svc_req,
  output logic              svc_nmi,
  output logic [ADDR_W-1:0] svc_addr,
  output logic              halt_n,
  output logic              iff_q,
  output logic              rst_clr
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] RST_LIM = CW'(RST_MIN);

  logic [CW-1:0] rst_cnt;
  logic rst_act, nmi_q, nmi_pend, granted, halted;
  logic nmi_fall, take_bus, take_nmi, take_int, take_any;

  assign rst_act  = (rst_cnt == RST_LIM);
  assign nmi_fall = nmi_q & ~nmi_n;
  assign take_bus = mcyc_end & ~busreq_n & ~granted;
  assign take_nmi = instr_end & nmi_pend & ~take_bus & ~granted;
  assign take_int = instr_end & ~int_n & iff_q & ~nmi_pend & ~take_bus & ~granted;
  assign take_any = take_nmi | take_int;

  assign busack_n  = ~granted;
  assign bus_float = granted;
  assign halt_n    = ~halted;
  assign rst_clr   = rst_act;

  always_ff @(posedge clk) begin
    if (rst_pin_n)    rst_cnt <= '0;
    else if (!rst_act) rst_cnt <= rst_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_act) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      granted  <= 1'b0;
      halted   <= 1'b0;
      iff_q    <= 1'b0;
      svc_req  <= 1'b0;
      svc_nmi  <= 1'b0;
      svc_addr <= '0;
    end else begin
      nmi_q    <= nmi_n;
      nmi_pend <= (nmi_pend & ~take_nmi) | nmi_fall;
      if (granted)       granted <= ~busreq_n;
      else if (take_bus) granted <= 1'b1;
      if (take_any)      halted <= 1'b0;
      else if (halt_req) halted <= 1'b1;
      if (take_any)      iff_q <= 1'b0;
      else if (ie_clr)   iff_q <= 1'b0;
      else if (ie_set)   iff_q <= 1'b1;
      svc_req <= take_any;
      if (take_any) begin
        svc_nmi  <= take_nmi;
        svc_addr <= take_nmi ? NMI_ADDR : INT_ADDR;
      end
    end
  end
endmodule

// File: rtl/irq_bus_arbiter_chk.sv
module irq_bus_arbiter_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_clr,
  input logic              busreq_n,
  input logic              int_n,
  input logic              mcyc_end,
  input logic              busack_n,
  input logic              svc_req,
  input logic              svc_nmi,
  input logic [ADDR_W-1:0] svc_addr,
  input logic              iff_q
);
  p_grant_on_mcyc_r2: assert property (@(posedge clk) disable iff (rst_clr)
    $fell(busack_n) |-> ($past(mcyc_end) && !$past(busreq_n)));
  p_bus_blocks_svc_r1: assert property (@(posedge clk) disable iff (rst_clr)
    !(svc_req && !busack_n));
  p_nmi_addr_r5: assert property (@(posedge clk) disable iff (rst_clr)
    (svc_req && svc_nmi) |-> (svc_addr == ADDR_W'(16'h0066)));
  p_int_needs_flag_r6: assert property (@(posedge clk) disable iff (rst_clr)
    (svc_req && !svc_nmi) |-> ($past(iff_q) && !$past(int_n)));
  p_take_clears_flag_r7: assert property (@(posedge clk) disable iff (rst_clr)
    svc_req |-> !iff_q);
endmodule

bind irq_bus_arbiter irq_bus_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_clr(rst_clr), .busreq_n(busreq_n), .int_n(int_n),
  .mcyc_end(mcyc_end), .busack_n(busack_n), .svc_req(svc_req),
  .svc_nmi(svc_nmi), .svc_addr(svc_addr), .iff_q(iff_q)
);

// File: tb/sim_irq_bus_arbiter.sv
module sim_irq_bus_arbiter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_pin_n = 1'b1, busreq_n = 1'b1, nmi_n = 1'b1, int_n = 1'b1;
  logic mcyc_end = 1'b0, instr_end = 1'b0, ie_set = 1'b0, ie_clr = 1'b0, halt_req = 1'b0;
  logic busack_n, bus_float, svc_req, svc_nmi, halt_n, iff_q, rst_clr;
  logic [15:0] svc_addr;

  irq_bus_arbiter u0 (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {ie, nmi_fall, int_active, bus_req, expected[1:0]}: 0 none, 1 bus, 2 nmi, 3 int
  localparam logic [5:0] VEC [10] = '{
    6'b1000_00, 6'b1010_11, 6'b0010_00, 6'b1100_10, 6'b1110_10,
    6'b0110_10, 6'b1001_01, 6'b1111_01, 6'b0101_01, 6'b1011_01 };

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_pin_n = 1'b0;
    repeat (4) tick();
    rst_pin_n = 1'b1;
    tick();
  endtask

  task automatic boundary(input logic mc, input logic ie);
    mcyc_end = mc; instr_end = ie; tick();
    mcyc_end = 1'b0; instr_end = 1'b0;
  endtask

  initial begin
    #40000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    rst_pin_n = 1'b0;
    repeat (3) tick();
    chk(rst_clr == 1'b1, "R8 qualified reset", rst_clr, 1);
    tick();
    rst_pin_n = 1'b1;
    tick();
    chk(rst_clr == 1'b0, "R8 release", rst_clr, 0);
    chk(busack_n && !bus_float, "R9 R3 bus idle", {busack_n, bus_float}, 2'b10);
    chk(halt_n && !svc_req && !iff_q, "R9 reset state", {halt_n, svc_req, iff_q}, 3'b100);

    for (int i = 0; i < 10; i++) begin
      logic [1:0] e;
      e = VEC[i][1:0];
      do_reset();
      if (VEC[i][5]) begin ie_set = 1'b1; tick(); ie_set = 1'b0; end
      if (VEC[i][4]) begin nmi_n = 1'b0; tick(); nmi_n = 1'b1; end
      int_n = ~VEC[i][3]; busreq_n = ~VEC[i][2];
      boundary(1'b1, 1'b1);
      chk(busack_n == (e != 2'd1), "R1 R3 grant", busack_n, e != 2'd1);
      chk(svc_req == e[1], "R1 service", svc_req, e[1]);
      if (e == 2'd2)
        chk(svc_nmi && svc_addr == 16'h0066, "R5 nmi addr", svc_addr, 16'h0066);
      if (e == 2'd3)
        chk(!svc_nmi && svc_addr == 16'h0038, "R6 int addr", svc_addr, 16'h0038);
      int_n = 1'b1; busreq_n = 1'b1; tick();
      chk(busack_n == 1'b1, "R2 release", busack_n, 1);
    end

    do_reset();
    ie_set = 1'b1; tick(); ie_set = 1'b0;
    rst_pin_n = 1'b0; repeat (2) tick(); rst_pin_n = 1'b1; tick();
    chk(iff_q == 1'b1 && rst_clr == 1'b0, "R8 short pulse ignored", iff_q, 1);
    ie_set = 1'b1; ie_clr = 1'b1; tick(); ie_set = 1'b0; ie_clr = 1'b0;
    chk(iff_q == 1'b0, "R7 clear wins", iff_q, 0);

    busreq_n = 1'b0; repeat (2) tick();
    chk(busack_n == 1'b1, "R2 waits for mcyc_end", busack_n, 1);
    boundary(1'b1, 1'b0);
    chk(busack_n == 1'b0 && bus_float == 1'b1, "R2 R3 grant mid instruction", busack_n, 0);
    nmi_n = 1'b0; tick(); nmi_n = 1'b1;
    boundary(1'b1, 1'b1);
    chk(svc_req == 1'b0, "R1 no service while granted", svc_req, 0);
    busreq_n = 1'b1; tick();
    chk(busack_n == 1'b1 && bus_float == 1'b0, "R2 R3 release", busack_n, 1);
    repeat (5) tick();
    boundary(1'b1, 1'b1);
    chk(svc_req && svc_nmi, "R4 pending held", {svc_req, svc_nmi}, 2'b11);
    tick();
    chk(svc_req == 1'b0, "R11 one-cycle pulse", svc_req, 0);
    boundary(1'b1, 1'b1);
    chk(svc_req == 1'b0, "R5 pending cleared", svc_req, 0);

    nmi_n = 1'b0; tick();
    boundary(1'b1, 1'b1);
    chk(svc_req == 1'b1, "R4 edge taken", svc_req, 1);
    tick();
    boundary(1'b1, 1'b1);
    chk(svc_req == 1'b0, "R4 held low no retrigger", svc_req, 0);
    nmi_n = 1'b1; tick();

    ie_set = 1'b1; int_n = 1'b0; tick(); ie_set = 1'b0;
    repeat (3) tick();
    chk(svc_req == 1'b0, "R6 needs instr_end", svc_req, 0);
    ie_set = 1'b1; boundary(1'b1, 1'b1); ie_set = 1'b0;
    chk(svc_req && !svc_nmi && iff_q == 1'b0, "R6 R7 int taken clears flag", iff_q, 0);
    boundary(1'b1, 1'b1);
    chk(svc_req == 1'b0, "R7 masked after take", svc_req, 0);
    int_n = 1'b1; tick();

    halt_req = 1'b1; tick(); halt_req = 1'b0;
    chk(halt_n == 1'b0, "R10 halt entered", halt_n, 0);
    int_n = 1'b0; boundary(1'b1, 1'b1); int_n = 1'b1;
    chk(halt_n == 1'b0 && !svc_req, "R10 masked int keeps halt", halt_n, 0);
    busreq_n = 1'b0; boundary(1'b1, 1'b0); busreq_n = 1'b1; tick();
    chk(halt_n == 1'b0, "R10 bus grant keeps halt", halt_n, 0);
    nmi_n = 1'b0; tick(); nmi_n = 1'b1;
    boundary(1'b1, 1'b1);
    chk(halt_n == 1'b1 && svc_req, "R10 nmi wakes", halt_n, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule